// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a fully associative translation buffer that maps a 64-bit virtual address onto a 41-bit physical page address. Each of its entries holds two 64-bit words. The tag word carries the virtual page number and a 13-bit address-space context. The translation word carries the valid flag, the page-size code, the physical page number and the permission flags. A lookup compares the request against every entry in the same cycle. A match requires three things: the entry is valid, the address agrees under that entry's own page-size mask, and one of three context rules holds.

A lookup request is presented for one cycle. The result arrives in the next cycle as exactly one of hit, miss or fault, together with the physical address and a write-permission flag. On the same clock edge the block records the details:

- A protection fault goes into a fault-status register and a fault-address register. If a second fault arrives before software has cleared the first, the status register shows overflow.
- A miss loads a tag-access register for the refill handler.

Software loads entries through a write port and inspects them through a read port. While translation is switched off, every address passes straight through, truncated to the physical width.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, so any translated lookup misses. The fault-status register, the fault-address register and the tag-access register read zero.
- R2: An entry matches only if its translation bit 63 (valid) is set and the request address equals the tag word under the page mask. The mask is taken from translation bits 62:61: code 0 clears the low 13 bits (8 KiB), code 1 the low 16 bits, code 2 the low 19 bits and code 3 the low 22 bits (4 MiB).
- R3: The context test on tag bits 12:0 passes in any of three cases: translation bit 0 (global) is set, the tag context equals the request context, or the nucleus flag is set and the tag context is zero.
- R4: On a hit the physical address is (translation word AND mask) OR (virtual address AND NOT mask), kept to bits 40:13, with bits 12:0 reading zero.
- R5: When several entries match, the entry with the lowest index supplies the result.
- R6: A fault is raised in either of two cases: a user access to a page with translation bit 2 (privileged) set, or a write to a page with translation bit 1 (writable) clear. On a fault the status register receives bit 0 = 1, bit 2 = write flag, bit 3 = user flag and bit 7 = 1 if privilege was violated. The fault-address register receives the virtual address.
- R7: If status bit 0 is already set when a fault arrives, the register is first replaced by 0x02 (overflow) and the bits of R6 are then ORed in.
- R8: On a miss, tag-access receives the virtual address with bits 12:0 cleared, ORed with the 13-bit request context.
- R9: A hit without a fault sets translation bit 41 (used) of the winning entry. A fault leaves that bit alone. Entries are read back through the read port.
- R10: While translation is disabled, a lookup reports a hit with write permission and physical address equal to virtual bits 40:0. It records nothing in the three registers.
- R11: A clear strobe zeroes the fault-status register on the next edge. A fault arriving in the same cycle is recorded on top of the zero.
- R12: The result of a lookup appears in the cycle after the request, with exactly one of hit, miss or fault set. On a hit, the write-permission output equals translation bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low bypasses the buffer |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Primary context of the request |
| lk_user | input | 1 | Request made in user mode |
| lk_write | input | 1 | Request is a write |
| lk_nucleus | input | 1 | Request made at nonzero trap level |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word to write |
| wr_tte | input | 64 | Translation word to write |
| rd_idx | input | 6 | Entry index to read back |
| rd_tte | output | 64 | Translation word of entry rd_idx |
| status_clr | input | 1 | Clear strobe for the fault-status register |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed every entry |
| rsp_fault | output | 1 | Lookup hit but broke a permission |
| rsp_paddr | output | 41 | Physical address |
| rsp_can_write | output | 1 | Hit page is writable |
| fault_status | output | 8 | Fault-status register |
| fault_addr | output | 64 | Fault-address register |
| tag_access | output | 64 | Tag-access register |

## Verification
The hardest state to reach from the ports is the overflow case. It needs a fault to land while the status register still holds an earlier, uncleared fault. It must also be the kind of fault that sets different flag bits, so that the overwrite with 0x02 can be told apart from a plain OR. The stimulus records a privilege fault, clears it, then records a write fault in privileged mode. It follows that at once with a user write to the privileged read-only page, and expects 0x8F.

The priority rule and the nucleus rule need deliberately overlapping entries. These are two entries with the same address and context but different physical pages, and an entry with context zero that is looked up with and without the nucleus flag.

// File: rtl/tlb_pkg.sv
// Package: shared widths, translation-word bit positions and the page-mask
// function used by the translation buffer. Assumes 64-bit words.
package tlb_pkg;
    localparam int VA_W    = 64;
    localparam int PA_W    = 41;
    localparam int CTX_W   = 13;
    localparam int PG_BASE = 13;

    localparam int TTE_VALID = 63;
    localparam int TTE_SZ_HI = 62;
    localparam int TTE_SZ_LO = 61;
    localparam int TTE_USED  = 41;
    localparam int TTE_PRIV  = 2;
    localparam int TTE_WR    = 1;
    localparam int TTE_GLB   = 0;

    // Mask keeping the page-number bits for a size code (13 + 3*code).
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] code);
        return {VA_W{1'b1}} << (PG_BASE + 3 * int'(code));
    endfunction
endpackage

// File: rtl/tlb_entry_match.sv
// Module: compare logic for one entry. Decides whether the request address
// and context select this entry. Assumes the tag holds the context in its
// low 13 bits and the page number above them.
module tlb_entry_match
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]  tag,
    input  logic             ent_valid,
    input  logic [1:0]       ent_size,
    input  logic             ent_global,
    input  logic [VA_W-1:0]  va,
    input  logic [CTX_W-1:0] ctx,
    input  logic             nucleus,
    output logic             hit
);
    logic [VA_W-1:0] mask;
    logic            ctx_ok;
    logic            va_ok;

    // Combine the valid flag, the context rules and the masked address test.
    always_comb begin
        mask   = page_mask(ent_size);
        ctx_ok = ent_global || (tag[CTX_W-1:0] == ctx) ||
                 (nucleus && (tag[CTX_W-1:0] == '0));
        va_ok  = ((va ^ tag) & mask) == '0;
        hit    = ent_valid && ctx_ok && va_ok;
    end
endmodule

// File: rtl/tlb_pick.sv
// Module: priority selector. Returns the lowest set index of a hit vector and
// whether any bit is set. Assumes N is at least 2.
module tlb_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan downward so the lowest matching index is the one kept.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
// Module: context-tagged fully associative translation buffer (top).
// Holds the entries, performs a one-cycle registered lookup, and keeps the
// fault-status, fault-address and tag-access registers. Assumes a
// synchronous active-low reset and at most one lookup per cycle.
module ctx_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlat_en,
    input  logic             lk_valid,
    input  logic [63:0]      lk_vaddr,
    input  logic [12:0]      lk_ctx,
    input  logic             lk_user,
    input  logic             lk_write,
    input  logic             lk_nucleus,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_tag,
    input  logic [63:0]      wr_tte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_tte,
    input  logic             status_clr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [40:0]      rsp_paddr,
    output logic             rsp_can_write,
    output logic [7:0]       fault_status,
    output logic [63:0]      fault_addr,
    output logic [63:0]      tag_access
);
    logic [VA_W-1:0]  tag_q [NUM_ENTRIES];
    logic [VA_W-1:0]  tte_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hits;
    logic [IDX_W-1:0] sel_idx;
    logic             any_hit;
    logic [VA_W-1:0]  sel_tte;
    logic [VA_W-1:0]  sel_mask;
    logic [VA_W-1:0]  pa_full;
    logic             priv_viol;
    logic             wr_viol;
    logic             xl_req;
    logic             fault_now;
    logic             hit_ok;
    logic             miss_now;
    logic [7:0]       status_base;
    logic [7:0]       status_nxt;
    logic [NUM_ENTRIES-1:0] lower_mask;

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            // Compare this entry against the request.
            tlb_entry_match u_match (
                .tag        (tag_q[g]),
                .ent_valid  (tte_q[g][TTE_VALID]),
                .ent_size   (tte_q[g][TTE_SZ_HI:TTE_SZ_LO]),
                .ent_global (tte_q[g][TTE_GLB]),
                .va         (lk_vaddr),
                .ctx        (lk_ctx),
                .nucleus    (lk_nucleus),
                .hit        (hits[g])
            );

            // Entry storage: reset invalidates, a write loads, a clean hit marks used.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tte_q[g] <= '0;
                    tag_q[g] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    tte_q[g] <= wr_tte;
                    tag_q[g] <= wr_tag;
                end else if (hit_ok && (sel_idx == IDX_W'(g))) begin
                    tte_q[g][TTE_USED] <= 1'b1;
                end
            end
        end
    endgenerate

    tlb_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hits (hits),
        .idx  (sel_idx),
        .any  (any_hit)
    );

    // Read port for software inspection of an entry.
    assign rd_tte = tte_q[rd_idx];

    // Permission checks, physical address and the next fault status.
    always_comb begin
        sel_tte     = tte_q[sel_idx];
        sel_mask    = page_mask(sel_tte[TTE_SZ_HI:TTE_SZ_LO]);
        pa_full     = (sel_tte & sel_mask) | (lk_vaddr & ~sel_mask);
        priv_viol   = sel_tte[TTE_PRIV] && lk_user;
        wr_viol     = !sel_tte[TTE_WR] && lk_write;
        xl_req      = lk_valid && xlat_en;
        fault_now   = xl_req && any_hit && (priv_viol || wr_viol);
        hit_ok      = xl_req && any_hit && !(priv_viol || wr_viol);
        miss_now    = xl_req && !any_hit;
        status_base = status_clr ? 8'h00 : fault_status;
        if (status_base[0]) status_base = 8'h02;
        status_nxt  = status_base | {priv_viol, 3'b000, lk_user, lk_write, 1'b0, 1'b1};
        lower_mask  = ({{(NUM_ENTRIES-1){1'b0}}, 1'b1} << sel_idx) - 1'b1;
    end

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_miss      <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_can_write <= 1'b0;
        end else begin
            rsp_valid     <= lk_valid;
            rsp_hit       <= lk_valid && (!xlat_en || hit_ok);
            rsp_miss      <= miss_now;
            rsp_fault     <= fault_now;
            rsp_paddr     <= xlat_en ? {pa_full[PA_W-1:PG_BASE], {PG_BASE{1'b0}}}
                                     : lk_vaddr[PA_W-1:0];
            rsp_can_write <= !xlat_en || sel_tte[TTE_WR];
        end
    end

    // Fault-status, fault-address and tag-access registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_status <= '0;
            fault_addr   <= '0;
            tag_access   <= '0;
        end else begin
            if (fault_now) begin
                fault_status <= status_nxt;
                fault_addr   <= lk_vaddr;
            end else if (status_clr) begin
                fault_status <= '0;
            end
            if (miss_now) tag_access <= {lk_vaddr[VA_W-1:CTX_W], lk_ctx};
        end
    end

    // R12: one outcome per valid result, none otherwise.
    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
    // R5: the selected entry matches and no lower entry does.
    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hits[sel_idx] && ((hits & lower_mask) == '0)));
    // R6: a reported fault is recorded with its address.
    assert_fault_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (fault_status[0] && (fault_addr == $past(lk_vaddr))));
    // R7: a fault over a pending fault flags overflow.
    assert_no_lost_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && fault_now && fault_status[0] && !status_clr) |-> fault_status[1]);
    // R8: a miss leaves page number and context in tag-access.
    assert_miss_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (tag_access == {$past(lk_vaddr[63:13]), $past(lk_ctx)}));
    // R10: bypassed lookups never miss or fault.
    assert_bypass_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lk_valid && !xlat_en) |-> (rsp_hit && !rsp_miss && !rsp_fault));
    // R11: a clear without a fault zeroes the status.
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && status_clr && !fault_now) |-> (fault_status == 8'h00));
endmodule

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_vaddr = '0;
    logic [12:0] lk_ctx = '0;
    logic        lk_user = 1'b0;
    logic        lk_write = 1'b0;
    logic        lk_nucleus = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0;
    logic [63:0] wr_tte = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_tte;
    logic        status_clr = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_can_write;
    logic [40:0] rsp_paddr;
    logic [7:0]  fault_status;
    logic [63:0] fault_addr, tag_access;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] V = 64'h8000_0000_0000_0000;

    ctx_tlb u_ctx_tlb (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tte(input logic [1:0] sz, input logic [40:0] pa,
                                           input logic wr, input logic pr, input logic gl);
        return V | (64'(sz) << 61) | (64'(pa) & 64'h1FF_FFFF_E000) |
               (64'(pr) << 2) | (64'(wr) << 1) | 64'(gl);
    endfunction

    function automatic logic [63:0] mk_tag(input logic [63:0] va, input logic [12:0] c);
        return {va[63:13], c};
    endfunction

    function automatic logic [40:0] exp_pa(input logic [63:0] tte, input logic [63:0] va,
                                           input int shift);
        logic [63:0] m;
        m = {64{1'b1}} << shift;
        return 41'(((tte & m) | (va & ~m)) & 64'h1FF_FFFF_E000);
    endfunction

    task automatic put(input int idx, input logic [63:0] tag, input logic [63:0] tte);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = tag; wr_tte = tte;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [63:0] va, input logic [12:0] c, input logic u,
                        input logic w, input logic n);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_ctx = c; lk_user = u; lk_write = w; lk_nucleus = n;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic clr_status();
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", 64'(fault_status), 0);
        chk("R1 faddr", fault_addr, 0);
        chk("R1 tagacc", tag_access, 0);
        look(64'h1234_6000, 13'd7, 0, 0, 0);
        chk("R1 miss", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 4'b1010);
        chk("R8 tagacc", tag_access, 64'h1234_6007);
    endtask

    task automatic t_basic();
        logic [63:0] t;
        t = mk_tte(2'd0, 41'h0AB_CDE0_2000, 1, 0, 0);
        put(5, mk_tag(64'h1234_6000, 13'd7), t);
        look(64'h1234_6ABC, 13'd7, 1, 1, 0);
        chk("R12 hit", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 4'b1100);
        chk("R4 paddr 8K", 64'(rsp_paddr), 64'(exp_pa(t, 64'h1234_6ABC, 13)));
        chk("R12 canwr", 64'(rsp_can_write), 1);
        rd_idx = 6'd5; #1;
        chk("R9 used", 64'(rd_tte[41]), 1);
        look(64'h1234_6ABC, 13'd8, 0, 0, 0);
        chk("R3 ctx mismatch", 64'(rsp_miss), 1);
        chk("R8 tagacc", tag_access, 64'h1234_6008);
    endtask

    task automatic t_sizes();
        logic [63:0] t;
        t = mk_tte(2'd3, 41'h1_0040_0000, 0, 0, 0);
        put(10, mk_tag(64'h4000_0000, 13'd3), t);
        look(64'h4012_3456, 13'd3, 0, 0, 0);
        chk("R2 4M hit", 64'(rsp_hit), 1);
        chk("R4 paddr 4M", 64'(rsp_paddr), 64'(exp_pa(t, 64'h4012_3456, 22)));
        chk("R12 canwr ro", 64'(rsp_can_write), 0);
        look(64'h4040_0000, 13'd3, 0, 0, 0);
        chk("R2 4M outside", 64'(rsp_miss), 1);
        t = mk_tte(2'd1, 41'h0_5550_0000, 1, 0, 0);
        put(12, mk_tag(64'h8_0000_0000, 13'h1FFF), t);
        look(64'h8_0000_F123, 13'h1FFF, 0, 0, 0);
        chk("R2 64K hit", 64'(rsp_hit), 1);
        chk("R4 paddr 64K", 64'(rsp_paddr), 64'(exp_pa(t, 64'h8_0000_F123, 16)));
        look(64'h8_0001_0000, 13'h1FFF, 0, 0, 0);
        chk("R2 64K outside", 64'(rsp_miss), 1);
        t = mk_tte(2'd2, 41'h0_7780_0000, 1, 0, 0);
        put(13, mk_tag(64'h10_0000_0000, 13'd4), t);
        look(64'h10_0007_E000, 13'd4, 0, 0, 0);
        chk("R2 512K hit", 64'(rsp_hit), 1);
        chk("R4 paddr 512K", 64'(rsp_paddr), 64'(exp_pa(t, 64'h10_0007_E000, 19)));
        look(64'h10_0008_0000, 13'd4, 0, 0, 0);
        chk("R2 512K outside", 64'(rsp_miss), 1);
    endtask

    task automatic t_context();
        put(20, mk_tag(64'h9000_0000, 13'd5), mk_tte(2'd0, 41'h0_1111_0000, 1, 0, 1));
        look(64'h9000_0000, 13'd9, 0, 0, 0);
        chk("R3 global", 64'(rsp_hit), 1);
        put(21, mk_tag(64'hA000_0000, 13'd0), mk_tte(2'd0, 41'h0_2222_0000, 1, 0, 0));
        look(64'hA000_0000, 13'd4, 0, 0, 1);
        chk("R3 nucleus", 64'(rsp_hit), 1);
        look(64'hA000_0000, 13'd4, 0, 0, 0);
        chk("R3 no nucleus", 64'(rsp_miss), 1);
    endtask

    task automatic t_priority();
        put(40, mk_tag(64'hB000_0000, 13'd2), mk_tte(2'd0, 41'h0_4444_0000, 1, 0, 0));
        put(30, mk_tag(64'hB000_0000, 13'd2), mk_tte(2'd0, 41'h0_3333_0000, 1, 0, 0));
        look(64'hB000_0000, 13'd2, 0, 0, 0);
        chk("R5 lowest", 64'(rsp_paddr), 64'h0_3333_0000);
    endtask

    task automatic t_faults();
        put(50, mk_tag(64'hC000_0000, 13'd1), mk_tte(2'd0, 41'h0_5000_0000, 0, 1, 0));
        put(51, mk_tag(64'hC100_0000, 13'd1), mk_tte(2'd0, 41'h0_5100_0000, 0, 0, 0));
        clr_status();
        look(64'hC000_0010, 13'd1, 1, 0, 0);
        chk("R6 priv fault", {rsp_hit, rsp_miss, rsp_fault}, 3'b001);
        chk("R6 status", 64'(fault_status), 64'h89);
        chk("R6 faddr", fault_addr, 64'hC000_0010);
        rd_idx = 6'd50; #1;
        chk("R9 not used", 64'(rd_tte[41]), 0);
        clr_status();
        chk("R11 cleared", 64'(fault_status), 0);
        look(64'hC100_0020, 13'd1, 0, 1, 0);
        chk("R6 write fault", 64'(fault_status), 64'h05);
        look(64'hC000_0030, 13'd1, 1, 1, 0);
        chk("R7 overflow", 64'(fault_status), 64'h8F);
        chk("R6 faddr2", fault_addr, 64'hC000_0030);
    endtask

    task automatic t_bypass();
        logic [63:0] ta;
        ta = tag_access;
        xlat_en = 1'b0;
        look(64'hFFFF_FFFF_FFFF_FFFF, 13'd3, 1, 1, 0);
        chk("R10 bypass", {rsp_hit, rsp_miss, rsp_fault, rsp_can_write}, 4'b1001);
        chk("R10 paddr", 64'(rsp_paddr), 64'h1FF_FFFF_FFFF);
        chk("R10 status kept", 64'(fault_status), 64'h8F);
        chk("R10 tagacc kept", tag_access, ta);
        xlat_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_context();
        t_priority();
        t_faults();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule